// File: doc/BRIEF.md
# Parallel-Bus SAR Converter Sequencer

This block runs a 16-bit successive-approximation converter that has a parallel result bus, on behalf of a host. It drives the converter's active-low chip-select, its read/convert select and its reset line, and it watches the converter's active-low end-of-conversion output. On the host side there is a start request and a power-mode choice. The block returns a 16-bit result with a one-cycle valid strobe, a busy flag and a timeout pulse.

Each conversion follows a fixed order. Chip-select falls once with read/convert low, which powers the converter up and starts acquisition. Chip-select falls a second time, which ends acquisition and starts the conversion. The read/convert level at that second edge selects whether the reference stays powered afterwards (standby) or is switched off (shutdown). The block then waits for end-of-conversion and lowers chip-select a third time, with read/convert high, to read the word. After a shutdown, or after any reset, the reference has to wake up again. The block therefore stretches the gap between the first and second edges of the next conversion to a wake-up count. Every time interval is a parameter counted in clock cycles.

Top module: `adc_seq_top`

## Requirements
- R1: Chip-select falls for the first time in a conversion only while read/convert is low, and read/convert has held its value for at least one clock before every falling edge of chip-select.
- R2: At the second falling edge, read/convert equals the mode latched from `mode_shdn_i` when the start was accepted (1 = shutdown, 0 = standby). Chip-select stays low for at least CSL_CYC cycles and high for at least CSH_CYC cycles between falling edges.
- R3: From the first to the second falling edge there are exactly CSL_CYC + max(CSH_CYC, ACQ_CYC) cycles when the previous conversion ended in standby. There are CSL_CYC + max(WAKE_CYC, CSH_CYC, ACQ_CYC) cycles when it ended in shutdown, and also after power-up or after a reset pulse.
- R4: Only after end-of-conversion has fallen does the block lower chip-select with read/convert high to read. It captures the bus while chip-select is low, on the last low cycle, and ignores the bus value at any other time.
- R5: `res_valid_o` is high for exactly one cycle per completed conversion, and `res_data_o` then carries the word that was read.
- R6: A start request that arrives while `busy_o` is high is ignored. It produces no extra conversion and does not change the latched mode.
- R7: If end-of-conversion has not fallen EOC_TMO_CYC cycles after the conversion state is entered, `timeout_o` pulses for one cycle. No result is produced, a converter reset pulse follows, and the reference is then treated as shut down.
- R8: The converter reset line is high for exactly RST_CYC cycles after power-up and after each timeout, and only while chip-select is high.
- R9: During and right after reset, chip-select is high, `res_valid_o` and `timeout_o` are low, and `busy_o` is high until the start-up reset pulse has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, taken when idle |
| mode_shdn_i | input | 1 | 1: shut the reference down after this conversion, 0: keep it in standby |
| busy_o | output | 1 | Sequence in progress |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| res_data_o | output | 16 | Last captured conversion word |
| timeout_o | output | 1 | One-cycle pulse when end-of-conversion never arrived |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_rc_o | output | 1 | Converter read/convert select |
| adc_reset_o | output | 1 | Converter reset pulse, active high |
| adc_eoc_n_i | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_data_i | input | 16 | Converter parallel data bus |

## Verification
The bench models the converter. It measures the gap between the first and second chip-select edges after standby, after shutdown and after a timeout. A design that forgets the wake-up state would convert too early, and one that always waits would show a gap that is too long. The model drives a wrong word on the bus whenever chip-select is high, so a capture taken at the wrong moment returns that wrong word. A converter that never signals end-of-conversion must lead to a timeout and a reset pulse taken with chip-select high. A start pulsed in the middle of a conversion must not add a second acquisition edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_RESET,
        ST_IDLE,
        ST_SETUP,
        ST_ACQ_LO,
        ST_GAP,
        ST_HOLD_LO,
        ST_CONV,
        ST_RD_SETUP,
        ST_RD_LO,
        ST_DONE,
        ST_RECOVER
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       mode;      // latched power-mode choice, 1 = shutdown
        logic       ref_off;   // reference assumed powered down
        logic       tmo;       // timeout pulse
        logic       eoc_meta;
        logic       eoc_sync;
    } seq_ctl_t;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic          valid,
    output logic [DW-1:0] dout
);

    logic          valid_d, valid_q;
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        valid_d = cap_en;
        data_d  = cap_en ? din : data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= valid_d;
            data_q  <= data_d;
        end
    end

    assign valid = valid_q;
    assign dout  = data_q;

    // R5
    cap_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (valid_q && data_q == $past(din)));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int DW          = 16,
    parameter int CSL_CYC     = 2,
    parameter int CSH_CYC     = 3,
    parameter int ACQ_CYC     = 8,
    parameter int WAKE_CYC    = 1500000,
    parameter int EOC_TMO_CYC = 600,
    parameter int RST_CYC     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_shdn_i,
    output logic          busy_o,
    output logic          res_valid_o,
    output logic [DW-1:0] res_data_o,
    output logic          timeout_o,
    output logic          adc_cs_n_o,
    output logic          adc_rc_o,
    output logic          adc_reset_o,
    input  logic          adc_eoc_n_i,
    input  logic [DW-1:0] adc_data_i
);
    import adc_seq_pkg::*;

    localparam int GAP_FAST = (CSH_CYC > ACQ_CYC) ? CSH_CYC : ACQ_CYC;
    localparam int GAP_WAKE = (WAKE_CYC > GAP_FAST) ? WAKE_CYC : GAP_FAST;
    localparam int MAX_A    = (GAP_WAKE > EOC_TMO_CYC) ? GAP_WAKE : EOC_TMO_CYC;
    localparam int MAX_B    = (RST_CYC > CSL_CYC) ? RST_CYC : CSL_CYC;
    localparam int MAX_C    = (MAX_B > CSH_CYC) ? MAX_B : CSH_CYC;
    localparam int MAXC     = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int TW       = $clog2(MAXC + 1);

    seq_ctl_t      ctl_d, ctl_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          cap_en;

    adc_seq_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    adc_seq_capture #(.DW(DW)) capture_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (adc_data_i),
        .valid  (res_valid_o),
        .dout   (res_data_o)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.tmo      = 1'b0;
        ctl_d.eoc_meta = adc_eoc_n_i;
        ctl_d.eoc_sync = ctl_q.eoc_meta;
        tmr_load       = 1'b0;
        tmr_val        = '0;
        cap_en         = 1'b0;
        unique case (ctl_q.st)
            ST_PWRUP: begin
                ctl_d.st      = ST_RESET;
                ctl_d.ref_off = 1'b1;
                tmr_load      = 1'b1;
                tmr_val       = TW'(RST_CYC - 1);
            end
            ST_RESET: begin
                if (tmr_zero) ctl_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_SETUP;
                    ctl_d.mode = mode_shdn_i;
                end
            end
            ST_SETUP: begin
                ctl_d.st = ST_ACQ_LO;
                tmr_load = 1'b1;
                tmr_val  = TW'(CSL_CYC - 1);
            end
            ST_ACQ_LO: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = ctl_q.ref_off ? TW'(GAP_WAKE - 1) : TW'(GAP_FAST - 1);
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_HOLD_LO;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(CSL_CYC - 1);
                end
            end
            ST_HOLD_LO: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(EOC_TMO_CYC - 1);
                end
            end
            ST_CONV: begin
                if (!ctl_q.eoc_sync) begin
                    ctl_d.st = ST_RD_SETUP;
                end else if (tmr_zero) begin
                    ctl_d.st      = ST_RESET;
                    ctl_d.tmo     = 1'b1;
                    ctl_d.ref_off = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = TW'(RST_CYC - 1);
                end
            end
            ST_RD_SETUP: begin
                ctl_d.st = ST_RD_LO;
                tmr_load = 1'b1;
                tmr_val  = TW'(CSL_CYC - 1);
            end
            ST_RD_LO: begin
                if (tmr_zero) begin
                    cap_en        = 1'b1;
                    ctl_d.ref_off = ctl_q.mode;
                    ctl_d.st      = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = TW'(CSH_CYC - 1);
            end
            ST_RECOVER: begin
                if (tmr_zero) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_PWRUP, mode: 1'b1, ref_off: 1'b1, tmo: 1'b0,
                       eoc_meta: 1'b1, eoc_sync: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign adc_cs_n_o  = !(ctl_q.st inside {ST_ACQ_LO, ST_HOLD_LO, ST_RD_LO});
    assign adc_reset_o = (ctl_q.st == ST_RESET);
    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign timeout_o   = ctl_q.tmo;

    always_comb begin
        unique case (ctl_q.st)
            ST_SETUP, ST_ACQ_LO:         adc_rc_o = 1'b0;
            ST_GAP, ST_HOLD_LO, ST_CONV: adc_rc_o = ctl_q.mode;
            default:                     adc_rc_o = 1'b1;
        endcase
    end

    // R1
    rc_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n_o) |-> $stable(adc_rc_o));

    // R1
    first_edge_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_cs_n_o) && $past(ctl_q.st) == ST_SETUP) |-> !adc_rc_o);

    // R8
    reset_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset_o |-> adc_cs_n_o);

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(ctl_q.mode));

    // R7
    timeout_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (adc_reset_o && !res_valid_o));

endmodule

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;

    localparam int CSL  = 2;
    localparam int CSH  = 3;
    localparam int ACQ  = 6;
    localparam int WAKE = 40;
    localparam int TMO  = 30;
    localparam int RSTC = 3;
    localparam int G0   = (CSH > ACQ) ? CSH : ACQ;
    localparam logic [15:0] JUNK = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_shdn_i = 1'b0;
    logic        busy_o, res_valid_o, timeout_o;
    logic [15:0] res_data_o;
    logic        adc_cs_n_o, adc_rc_o, adc_reset_o;
    logic        adc_eoc_n_i = 1'b1;
    logic [15:0] adc_data_i;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // converter model state
    int          phase = 0;
    int          e1_cyc = 0;
    int          e2_cyc = 0;
    int          eoc_cnt = 0;
    int          n_first = 0;
    int          lo_len = 0;
    int          hi_len = 100;
    int          rst_len = 0;
    bit          prev_shdn = 1'b1;
    bit          no_eoc = 1'b0;
    bit          drive = 1'b0;
    bit          cs_prev = 1'b1;
    bit          rst_prev = 1'b0;
    bit          exp_mode = 1'b0;
    int          conv_delay = 5;
    logic [15:0] word = 16'h0000;

    always #4 clk = ~clk;

    assign adc_data_i = drive ? word : JUNK;

    adc_seq_top #(
        .DW(16), .CSL_CYC(CSL), .CSH_CYC(CSH), .ACQ_CYC(ACQ),
        .WAKE_CYC(WAKE), .EOC_TMO_CYC(TMO), .RST_CYC(RSTC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_shdn_i(mode_shdn_i),
        .busy_o(busy_o), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
        .timeout_o(timeout_o), .adc_cs_n_o(adc_cs_n_o), .adc_rc_o(adc_rc_o),
        .adc_reset_o(adc_reset_o), .adc_eoc_n_i(adc_eoc_n_i), .adc_data_i(adc_data_i)
    );

    function automatic int exp_gap(bit shdn);
        int g;
        g = G0;
        if (shdn && WAKE > g) g = WAKE;
        return CSL + g;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    // converter model and protocol monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_reset_o && !rst_prev) begin
                check(adc_cs_n_o, "R8 reset with cs high", 0, 1);
            end
            if (adc_reset_o) begin
                rst_len++;
                phase = 0; prev_shdn = 1'b1; adc_eoc_n_i = 1'b1; drive = 1'b0;
            end else if (rst_prev) begin
                check(rst_len == RSTC, "R8 reset length", rst_len, RSTC);
                rst_len = 0;
            end
            rst_prev = adc_reset_o;

            if (cs_prev && !adc_cs_n_o) begin
                check(hi_len >= CSH, "R2 cs high time", hi_len, CSH);
                lo_len = 1;
                if (phase == 0) begin
                    check(adc_rc_o == 1'b0, "R1 rc at first edge", adc_rc_o, 0);
                    n_first++; e1_cyc = cyc; phase = 1;
                end else if (phase == 1) begin
                    check(adc_rc_o == exp_mode, "R2 rc at second edge", adc_rc_o, exp_mode);
                    check(cyc - e1_cyc == exp_gap(prev_shdn), "R3 acquisition gap",
                          cyc - e1_cyc, exp_gap(prev_shdn));
                    prev_shdn = adc_rc_o; e2_cyc = cyc;
                    adc_eoc_n_i = 1'b1; eoc_cnt = conv_delay; phase = 2;
                end else if (phase == 3) begin
                    check(adc_rc_o == 1'b1, "R4 rc at read edge", adc_rc_o, 1);
                    drive = 1'b1; phase = 4;
                end else begin
                    check(1'b0, "R4 unexpected cs edge", phase, 3);
                end
            end else if (!cs_prev && adc_cs_n_o) begin
                check(lo_len >= CSL, "R2 cs low time", lo_len, CSL);
                hi_len = 1;
                if (phase == 4) begin
                    drive = 1'b0; adc_eoc_n_i = 1'b1; phase = 0;
                end
            end else if (!adc_cs_n_o) begin
                lo_len++;
            end else begin
                hi_len++;
            end
            cs_prev = adc_cs_n_o;

            if (phase == 2 && !no_eoc) begin
                eoc_cnt--;
                if (eoc_cnt <= 0) begin
                    adc_eoc_n_i = 1'b0; phase = 3;
                end
            end
        end
    end

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy_o && n < 1000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic run_conv(bit mode, int dly, logic [15:0] w, bit poke_busy);
        int n = 0;
        int first0;
        wait_idle();
        exp_mode = mode; conv_delay = dly; word = w; first0 = n_first;
        mode_shdn_i = mode; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; mode_shdn_i = $urandom_range(0, 1);
        if (poke_busy) begin
            repeat (CSL + 2) @(negedge clk);
            start_i = 1'b1; mode_shdn_i = ~mode;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!res_valid_o && n < 2000) begin
            @(negedge clk); n++;
        end
        check(res_valid_o, "R5 valid seen", res_valid_o, 1);
        check(res_data_o == w, "R4 R5 captured word", res_data_o, w);
        @(negedge clk);
        check(!res_valid_o, "R5 valid one cycle", res_valid_o, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        check(n_first == first0 + 1, "R6 one acquisition per start", n_first - first0, 1);
        check(!busy_o, "R6 idle after busy start", busy_o, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R9 reset state
        check(adc_cs_n_o, "R9 cs high in reset", adc_cs_n_o, 1);
        check(!res_valid_o && !timeout_o, "R9 strobes low in reset", res_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o, "R9 busy during start-up", busy_o, 1);
        wait_idle();
        check(!busy_o, "R9 idle after start-up", busy_o, 0);

        // directed: first conversion after power-up waits wake-up (R3), standby then fast
        run_conv(1'b0, CSH, 16'h0000, 1'b0);
        run_conv(1'b0, CSH + 1, 16'hFFFF, 1'b0);
        run_conv(1'b1, 10, 16'h8001, 1'b0);
        run_conv(1'b0, 7, 16'h7FFE, 1'b1);

        // random sequence
        for (int i = 0; i < 20; i++) begin
            run_conv(1'($urandom_range(0, 1)), $urandom_range(CSH, TMO - 10),
                     16'($urandom), (i % 5) == 0);
        end

        // R7 timeout: no end-of-conversion
        begin
            int n = 0;
            int valids = 0;
            wait_idle();
            no_eoc = 1'b1; exp_mode = 1'b0;
            mode_shdn_i = 1'b0; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            while (!timeout_o && n < 500) begin
                if (res_valid_o) valids++;
                @(negedge clk); n++;
            end
            check(timeout_o, "R7 timeout pulse", timeout_o, 1);
            check((cyc - e2_cyc) >= TMO && (cyc - e2_cyc) <= TMO + CSL + 2,
                  "R7 timeout delay", cyc - e2_cyc, TMO + CSL);
            check(adc_reset_o && adc_cs_n_o, "R7 R8 reset follows timeout", adc_reset_o, 1);
            @(negedge clk);
            check(!timeout_o, "R7 timeout one cycle", timeout_o, 0);
            check(valids == 0 && !res_valid_o, "R7 no result", valids, 0);
            no_eoc = 1'b0;
        end
        // after timeout the wake-up gap applies again (R3), then standby
        run_conv(1'b0, 6, 16'h1234, 1'b0);
        run_conv(1'b0, 6, 16'hABCD, 1'b0);

        finish_run();
    end

endmodule